// File: doc/BRIEF.md
# Trimmed One-Second Timebase Divider

This block turns a nominal 32.768 kHz oscillator into the once-per-second tick that advances a real-time clock. The oscillator arrives as a single-cycle enable strobe on the system clock. A 32-bit trim register sets the timebase. Its low field is an integer divide count C, and the block emits one tick for every C+1 oscillator pulses that it accepts. Its upper field is a deletion count D. After every 1024 ticks, the next D oscillator pulses are swallowed before they reach the divider. The average period can therefore be stretched by a fraction of a pulse per second, without a finer divider.

Software loads the register through a plain write strobe with write data, and reads it back on a combinational read bus. A write restarts the divider, the period counter and any pending deletions, so new settings start from a clean boundary. When the register holds zero, trimming is off and every oscillator pulse becomes a tick. The oscillator strobe cannot be stalled, and the tick cannot be back-pressured: both are plain pins with no valid/ready handshake. A pulse that arrives during a write cycle is dropped.

Top module: `rtc_tick_gen`

## Requirements
- R1: After reset the trim register reads 0 on `rd_data`.
- R2: A write stores `wr_data[15:0]` as the divide count C and `wr_data[25:16]` as the deletion count D; bits 31:26 always read 0 and ignore writes.
- R3: While the register is all zeros, `tick` is high in exactly the cycles where `osc_en` is high and no write occurs.
- R4: With a non-zero register, `tick` is a one-cycle pulse, high in the cycle of the accepted `osc_en` that completes each group of C+1 accepted pulses.
- R5: After every 1024th tick, the next D `osc_en` pulses are deleted and do not count, so one full trim period spans 1024×(C+1)+D pulses.
- R6: A write clears the divider, the period counter and any pending deletions; an `osc_en` in the write cycle is ignored and `tick` stays low in that cycle; the first 1024 ticks after a write take exactly 1024×(C+1) pulses.
- R7: `tick` is never high in a cycle where `osc_en` is low.
- R8: With D = 0 and C non-zero, no pulse is ever deleted and the tick interval is exactly C+1 pulses.
- R9: With C = 0 and D non-zero, the block is still in trim mode, giving one tick per accepted pulse with D-pulse gaps, for a period of 1024+D pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One-cycle strobe per oscillator pulse |
| wr_en | input | 1 | Trim register write strobe |
| wr_data | input | 32 | Trim register write data |
| rd_data | output | 32 | Trim register read data |
| tick | output | 1 | One-cycle timebase tick |

## Verification
A divide counter that is off by one shows up on the very first tick after a write, as a tick one accepted pulse early or late. A corrupted deletion counter or period counter stays hidden until the 1024th tick. From that point every tick of the following trim period is shifted, and the period length differs from 1024×(C+1)+D. The bench compares `tick` with a behavioural model on every cycle. It also measures both the first and second 1024-tick spans directly, so a fault in the deletion logic is caught within one trim period.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  localparam int REG_W    = 32;
  localparam int DIV_W    = 16;
  localparam int DEL_W    = 10;
  localparam int PER_LOG2 = 10;
  localparam int FIELD_W  = DIV_W + DEL_W;

  // Upper field is the deletion count, lower field the divide count.
  typedef struct packed {
    logic [DEL_W-1:0] del;
    logic [DIV_W-1:0] div;
  } trim_cfg_t;
endpackage

// File: rtl/rtc_trim_cfg.sv
module rtc_trim_cfg
  import rtc_trim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output trim_cfg_t        cfg,
  output logic [REG_W-1:0] rd_data
);
  localparam int RSV_W = REG_W - FIELD_W;

  logic unused_rsvd;
  assign unused_rsvd = ^wr_data[REG_W-1:FIELD_W];

  always_ff @(posedge clk) begin
    if (!rst_n)     cfg <= '0;
    else if (wr_en) cfg <= trim_cfg_t'(wr_data[FIELD_W-1:0]);
  end

  assign rd_data = {{RSV_W{1'b0}}, cfg};

  // R2: a write lands in the fields on the next cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg == $past(wr_data[FIELD_W-1:0])));

  // R2: without a write the register holds
  a_r2_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg));
endmodule

// File: rtl/rtc_pulse_gobbler.sv
module rtc_pulse_gobbler
  import rtc_trim_pkg::*;
#(
  parameter int CW = DEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          osc_en,
  input  logic          reload,
  input  logic [CW-1:0] reload_cnt,
  output logic          pass
);
  logic [CW-1:0] left;
  logic          deleting;

  assign deleting = (left != '0);
  assign pass     = osc_en & ~restart & ~deleting;

  always_ff @(posedge clk) begin
    if (!rst_n || restart)       left <= '0;
    else if (reload)             left <= reload_cnt;
    else if (osc_en && deleting) left <= left - 1'b1;
  end

  // R5: each oscillator pulse during a gap consumes one deletion
  a_r5_gap_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (deleting && osc_en && !restart) |=> (left == $past(left) - 1'b1));

  // R5: a new gap is only loaded after the previous one has finished
  a_r5_reload_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> !deleting);

  // R6: a restart cancels pending deletions
  a_r6_restart_clears_gap: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !deleting);
endmodule

// File: rtl/rtc_tick_divider.sv
module rtc_tick_divider
  import rtc_trim_pkg::*;
#(
  parameter int W = DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt;
  logic         at_end;

  assign at_end = (cnt == limit);
  assign tick   = step & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (step)         cnt <= at_end ? '0 : cnt + 1'b1;
  end

  // R4: the count never runs past the programmed limit
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);

  // R6: a write restarts the divide from zero
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/rtc_period_counter.sv
module rtc_period_counter
  import rtc_trim_pkg::*;
#(
  parameter int LOG2 = PER_LOG2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic wrap
);
  logic [LOG2-1:0] pcnt;

  assign wrap = tick & (&pcnt);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pcnt <= '0;
    else if (tick)         pcnt <= pcnt + 1'b1;
  end

  // R5: the period restarts after its last tick
  a_r5_wrap_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !restart) |=> (pcnt == '0));
endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
  import rtc_trim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             tick
);
  trim_cfg_t cfg;
  logic      pass;
  logic      div_tick;
  logic      wrap;
  logic      bypass;

  rtc_trim_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg(cfg), .rd_data(rd_data)
  );

  rtc_pulse_gobbler #(.CW(DEL_W)) u_gob (
    .clk(clk), .rst_n(rst_n), .restart(wr_en), .osc_en(osc_en),
    .reload(wrap), .reload_cnt(cfg.del), .pass(pass)
  );

  rtc_tick_divider #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(wr_en), .step(pass),
    .limit(cfg.div), .tick(div_tick)
  );

  rtc_period_counter #(.LOG2(PER_LOG2)) u_per (
    .clk(clk), .rst_n(rst_n), .restart(wr_en), .tick(div_tick), .wrap(wrap)
  );

  assign bypass = (cfg == '0);
  assign tick   = bypass ? (osc_en & ~wr_en) : div_tick;

  // R7: no tick without an oscillator pulse
  a_r7_tick_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> osc_en);

  // R6: a write cycle never produces a tick
  a_r6_no_tick_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !tick);
endmodule

// File: tb/sim_rtc_tick_gen.sv
`timescale 1ns/1ps
module sim_rtc_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        osc_en;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        tick;

  always #2 clk = ~clk;

  rtc_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tick(tick)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural model state
  logic [31:0] m_reg;
  int m_cnt, m_pcnt, m_del;
  // span measurement from observed ticks
  longint obs_pulses, obs_ticks, mark_first;
  bit     span_seen;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit osc, input bit we, input logic [31:0] d);
    int  c, dl;
    bit  expt, acc;
    longint want;
    @(negedge clk);
    osc_en = osc; wr_en = we; wr_data = d;
    #1;
    c  = int'(m_reg[15:0]);
    dl = int'(m_reg[25:16]);
    acc  = osc && !we;
    expt = 1'b0;
    if (acc) begin
      if (m_reg[25:0] == 26'd0) expt = 1'b1;
      else if (m_del == 0 && m_cnt == c) expt = 1'b1;
    end
    chk(tick === expt, (m_reg == 0) ? "R3" : "R4", "tick vs model", longint'(tick), longint'(expt));
    if (!osc) chk(tick === 1'b0, "R7", "tick without osc_en", longint'(tick), 0);
    if (we)   chk(tick === 1'b0, "R6", "tick in write cycle", longint'(tick), 0);
    // observed span measurement
    if (acc && m_reg != 0) begin
      obs_pulses++;
      if (tick === 1'b1) begin
        obs_ticks++;
        if (obs_ticks == 1024) begin
          mark_first = obs_pulses;
          want = 1024 * (c + 1);
          chk(obs_pulses == want, "R6", "first span after write", obs_pulses, want);
        end
        if (obs_ticks == 2048) begin
          want = 1024 * (c + 1) + dl;
          chk(obs_pulses - mark_first == want, "R5", "full trim period", obs_pulses - mark_first, want);
          span_seen = 1'b1;
        end
      end
    end
    @(posedge clk);
    // model update
    if (we) begin
      m_reg = d & 32'h03FF_FFFF;
      m_cnt = 0; m_pcnt = 0; m_del = 0;
      obs_pulses = 0; obs_ticks = 0; mark_first = 0; span_seen = 1'b0;
    end else if (acc && m_reg != 0) begin
      if (m_del > 0) m_del--;
      else if (m_cnt == c) begin
        m_cnt = 0;
        if (m_pcnt == 1023) begin m_pcnt = 0; m_del = dl; end
        else m_pcnt++;
      end else m_cnt++;
    end
  endtask

  // mode 0: pulse every cycle; mode n: skip every n-th cycle; mode -n: pulse every n-th cycle
  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      bit o;
      if (mode == 0)     o = 1'b1;
      else if (mode > 0) o = (i % mode) != 0;
      else               o = (i % (-mode)) == 0;
      cyc(o, 1'b0, 32'h0);
    end
  endtask

  task automatic wr(input logic [31:0] d, input bit osc);
    cyc(osc, 1'b1, d);
    @(negedge clk); #1;
    chk(rd_data === (d & 32'h03FF_FFFF), "R2", "read back", longint'(rd_data), longint'(d & 32'h03FF_FFFF));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    m_reg = 0; m_cnt = 0; m_pcnt = 0; m_del = 0;
    obs_pulses = 0; obs_ticks = 0; mark_first = 0; span_seen = 0;
    rst_n = 1'b0; osc_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(rd_data === 32'h0, "R1", "reset register", longint'(rd_data), 0);
    chk(tick === 1'b0, "R1", "reset tick", longint'(tick), 0);

    // R3: bypass with mixed pulse patterns
    run(30, 3);
    run(30, -2);

    // R2 R5: C=3, D=5, reserved bits set; write with osc_en high (R6)
    wr(32'hFC05_0003, 1'b1);
    run(8300, 0);
    chk(span_seen, "R5", "period measured (C=3 D=5)", longint'(span_seen), 1);

    // R8: C=2, D=0, pulse every other cycle
    wr(32'h0000_0002, 1'b0);
    run(12400, -2);
    chk(span_seen, "R8", "period measured (D=0)", longint'(span_seen), 1);

    // R9: C=0, D=7, one missing pulse in five
    wr(32'h0007_0000, 1'b1);
    run(2700, 5);
    chk(span_seen, "R9", "period measured (C=0 D=7)", longint'(span_seen), 1);

    // R6: mid-run rewrite while pulses flow
    wr(32'h0001_0001, 1'b0);
    run(17, 0);
    wr(32'h0001_0004, 1'b1);
    run(40, 0);

    // R3: back to bypass
    wr(32'h0000_0000, 1'b1);
    run(20, 4);

    finish_up();
  end
endmodule